// File: doc/BRIEF.md
# Dual ADC Conversion Timing Sequencer

This block produces the converter clock and the timing of each conversion for two independent analog-to-digital converters. Both run from one system clock. Each instance has its own prescaler. The prescaler divides the system clock by an even ratio and emits a one-cycle clock enable, plus a square-wave clock output with 50% duty. A clock-frequency ceiling is fixed at elaboration. Any ratio that would drive the converter clock above that ceiling is rejected: it produces no clock, and an error bit latches.

A conversion begins with a one-cycle start pulse. The pulse carries a 2-bit sample-time code and a differential flag. The phase state machine moves through three states:

- IDLE: waiting for an accepted start.
- SAMPLE: counts converter clock enables for the number of cycles the code selects.
- CONVERT: counts 13 enables for a differential conversion or 14 for a single-ended one, then returns to IDLE.

The transitions are named as follows:

- IDLE→SAMPLE ("accept"): start is high, the current ratio is legal and no ratio change is pending.
- SAMPLE→CONVERT ("sample_end"): the enable that completes the last sampling cycle.
- CONVERT→IDLE ("conv_end"): the enable that completes the last conversion cycle. The done pulse fires in that same cycle.

A prescaler setting written while a conversion runs takes effect once the instance is idle again.

Top module: `adc_seq_timer`

## Requirements
- R1: For prescaler code N (5 bits), the divide ratio is 2×(N+1). With a legal ratio, `adc_en` is a one-cycle pulse exactly every 2×(N+1) system clocks.
- R2: A code is legal when SYS_CLK_HZ ≤ ADC_CLK_MAX_HZ × 2×(N+1). With the defaults (120 MHz, 12 MHz), codes 0 to 3 are illegal and code 4 is legal. While the applied code is illegal, `ratio_bad` is high and `adc_en` and `adc_clk` stay low.
- R3: `ratio_err` goes high once an illegal code has been applied, and it stays high until reset, even after a legal code is applied.
- R4: With a legal code, `adc_clk` is high for N+1 consecutive cycles and low for N+1 cycles. Each `adc_en` pulse falls in the last high cycle.
- R5: A new prescaler code is applied only while the instance is idle. During a conversion, the `adc_en` spacing keeps the old ratio.
- R6: An accepted start enters SAMPLE. `sample_ph` covers exactly 2, 8, 64 or 128 `adc_en` pulses for sample-time codes 00, 01, 10 and 11 respectively. `sample_ph` and `conv_ph` are never high together.
- R7: SAMPLE is followed directly by CONVERT. `conv_ph` covers 13 `adc_en` pulses when `diff`=1 and 14 when `diff`=0.
- R8: `done` is a one-cycle pulse that coincides with the `adc_en` pulse ending the last conversion cycle. `busy` is low in the following cycle.
- R9: A start is ignored while the instance is busy, while its applied code is illegal, or while a code change is pending.
- R10: The two instances are independent. The ratio, the error state and the conversions of one do not affect the other.
- R11: During reset, `adc_en`, `adc_clk`, `busy`, `sample_ph`, `conv_ph`, `done`, `ratio_err` and `ratio_bad` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps_set | input | NUM_INST×PS_W | Prescaler code per instance |
| start | input | NUM_INST | Start pulse per instance |
| ts_code | input | NUM_INST×2 | Sample-time code per instance |
| diff | input | NUM_INST | 1 = differential, 0 = single-ended |
| adc_en | output | NUM_INST | Converter clock enable pulse |
| adc_clk | output | NUM_INST | 50% duty converter clock |
| ratio_bad | output | NUM_INST | Applied code is illegal |
| ratio_err | output | NUM_INST | Sticky illegal-code flag |
| busy | output | NUM_INST | Conversion in progress |
| sample_ph | output | NUM_INST | Sampling phase active |
| conv_ph | output | NUM_INST | Conversion phase active |
| done | output | NUM_INST | One-cycle end-of-conversion pulse |

## Verification
Conversions are launched with all four sample-time codes and both conversion modes. Pulses are counted per phase, so an error in the code-to-length map can be told apart from an error in the convert length or the phase handover. The two instances run at different ratios at the same time, which would expose crosstalk. The ratio is also changed in mid-conversion, which separates deferred application of the code from immediate application. A sweep around the legality boundary (codes 3 and 4) exercises the threshold, the sticky flag and the refusal of starts. A repeated start during a long sample window shows that starts are ignored while busy.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    localparam int PH_W        = 8;
    localparam int CONV_DIFF   = 13;
    localparam int CONV_SINGLE = 14;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;

    // Sampling length in converter clocks for each 2-bit code.
    function automatic logic [PH_W-1:0] sample_len(input logic [1:0] code);
        logic [PH_W-1:0] len;
        unique case (code)
            2'd0:    len = PH_W'(2);
            2'd1:    len = PH_W'(8);
            2'd2:    len = PH_W'(64);
            default: len = PH_W'(128);
        endcase
        return len;
    endfunction

    // Smallest prescaler code N with sys_hz / (2*(N+1)) <= max_hz.
    function automatic int min_ps_code(input longint unsigned sys_hz,
                                       input longint unsigned max_hz);
        longint unsigned halves;
        halves = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (halves == 0) ? 0 : int'(halves) - 1;
    endfunction

endpackage

// File: rtl/adcq_clkdiv.sv
module adcq_clkdiv #(
    parameter int PS_W     = 5,
    parameter int MIN_CODE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic [PS_W-1:0] ps_set,
    output logic            adc_en,
    output logic            adc_clk,
    output logic            bad,
    output logic            err,
    output logic            ready
);
    localparam int CNT_W = PS_W + 1;

    logic [PS_W-1:0]  ps_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;
    logic [CNT_W-1:0] cnt_half;
    logic             legal;
    logic             reload;
    logic             clk_q;
    logic             err_q;

    assign cnt_last = {ps_act, 1'b1};   // 2N+1
    assign cnt_half = {1'b0, ps_act};   // N
    assign legal    = int'(ps_act) >= MIN_CODE;
    assign reload   = idle && (ps_set != ps_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_act <= '1;
            cnt    <= '0;
            clk_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reload) begin
                ps_act <= ps_set;
                cnt    <= '0;
                clk_q  <= 1'b0;
            end else if (!legal) begin
                cnt    <= '0;
                clk_q  <= 1'b0;
            end else begin
                cnt <= (cnt == cnt_last) ? '0 : cnt + 1'b1;
                if (cnt == cnt_half || cnt == cnt_last)
                    clk_q <= ~clk_q;
            end
            if (!legal)
                err_q <= 1'b1;
        end
    end

    assign adc_en  = legal && (cnt == cnt_last);
    assign adc_clk = clk_q;
    assign bad     = !legal;
    assign err     = err_q;
    assign ready   = legal && (ps_set == ps_act);

endmodule

// File: rtl/adcq_phase_seq.sv
module adcq_phase_seq
    import adcq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] ts_code,
    input  logic       diff,
    input  logic       ready,
    input  logic       tick,
    output logic       busy,
    output logic       sample_ph,
    output logic       conv_ph,
    output logic       done
);
    phase_e          state_q, state_d;
    logic [PH_W-1:0] pcnt_q, pcnt_d;
    logic [PH_W-1:0] slen_q, slen_d;
    logic            diff_q, diff_d;
    logic [PH_W-1:0] clen;
    logic            samp_last;
    logic            conv_last;

    assign clen      = diff_q ? PH_W'(CONV_DIFF) : PH_W'(CONV_SINGLE);
    assign samp_last = (pcnt_q == slen_q - 1'b1);
    assign conv_last = (pcnt_q == clen - 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            pcnt_q  <= '0;
            slen_q  <= '0;
            diff_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            slen_q  <= slen_d;
            diff_q  <= diff_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        slen_d  = slen_q;
        diff_d  = diff_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start && ready) begin            // accept
                    state_d = PH_SAMPLE;
                    pcnt_d  = '0;
                    slen_d  = sample_len(ts_code);
                    diff_d  = diff;
                end
            end
            PH_SAMPLE: begin
                if (tick) begin
                    if (samp_last) begin             // sample_end
                        state_d = PH_CONVERT;
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d  = pcnt_q + 1'b1;
                    end
                end
            end
            PH_CONVERT: begin
                if (tick) begin
                    if (conv_last) begin             // conv_end
                        state_d = PH_IDLE;
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d  = pcnt_q + 1'b1;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        sample_ph = 1'b0;
        conv_ph   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_SAMPLE: begin
                busy      = 1'b1;
                sample_ph = 1'b1;
            end
            PH_CONVERT: begin
                busy    = 1'b1;
                conv_ph = 1'b1;
                done    = tick && conv_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int              NUM_INST       = 2,
    parameter int              PS_W           = 5,
    parameter longint unsigned SYS_CLK_HZ     = 120_000_000,
    parameter longint unsigned ADC_CLK_MAX_HZ = 12_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_INST-1:0][PS_W-1:0]  ps_set,
    input  logic [NUM_INST-1:0]            start,
    input  logic [NUM_INST-1:0][1:0]       ts_code,
    input  logic [NUM_INST-1:0]            diff,
    output logic [NUM_INST-1:0]            adc_en,
    output logic [NUM_INST-1:0]            adc_clk,
    output logic [NUM_INST-1:0]            ratio_bad,
    output logic [NUM_INST-1:0]            ratio_err,
    output logic [NUM_INST-1:0]            busy,
    output logic [NUM_INST-1:0]            sample_ph,
    output logic [NUM_INST-1:0]            conv_ph,
    output logic [NUM_INST-1:0]            done
);
    localparam int MIN_CODE = adcq_pkg::min_ps_code(SYS_CLK_HZ, ADC_CLK_MAX_HZ);

    for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
        logic ready;

        adcq_clkdiv #(
            .PS_W     (PS_W),
            .MIN_CODE (MIN_CODE)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .idle    (!busy[g]),
            .ps_set  (ps_set[g]),
            .adc_en  (adc_en[g]),
            .adc_clk (adc_clk[g]),
            .bad     (ratio_bad[g]),
            .err     (ratio_err[g]),
            .ready   (ready)
        );

        adcq_phase_seq u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[g]),
            .ts_code   (ts_code[g]),
            .diff      (diff[g]),
            .ready     (ready),
            .tick      (adc_en[g]),
            .busy      (busy[g]),
            .sample_ph (sample_ph[g]),
            .conv_ph   (conv_ph[g]),
            .done      (done[g])
        );
    end

endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk #(
    parameter int NUM_INST = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_INST-1:0] adc_en,
    input logic [NUM_INST-1:0] adc_clk,
    input logic [NUM_INST-1:0] ratio_bad,
    input logic [NUM_INST-1:0] ratio_err,
    input logic [NUM_INST-1:0] busy,
    input logic [NUM_INST-1:0] sample_ph,
    input logic [NUM_INST-1:0] conv_ph,
    input logic [NUM_INST-1:0] done
);
    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        AST_EN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            adc_en[i] |=> !adc_en[i]);                                    // R1
        AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            ratio_bad[i] |-> (!adc_en[i] && !adc_clk[i]));                // R2
        AST_BAD_LATCHES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
            ratio_bad[i] |=> ratio_err[i]);                               // R3
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ratio_err[i] |=> ratio_err[i]);                               // R3
        AST_EN_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            adc_en[i] |-> adc_clk[i]);                                    // R4
        AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(sample_ph[i] && conv_ph[i]));                               // R6
        AST_SAMPLE_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sample_ph[i]) |-> conv_ph[i]);                          // R7
        AST_DONE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> (adc_en[i] && conv_ph[i]));                       // R8
        AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> (!busy[i] && !done[i]));                          // R8
    end
endmodule

bind adc_seq_timer adc_seq_timer_chk #(.NUM_INST(NUM_INST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_en    (adc_en),
    .adc_clk   (adc_clk),
    .ratio_bad (ratio_bad),
    .ratio_err (ratio_err),
    .busy      (busy),
    .sample_ph (sample_ph),
    .conv_ph   (conv_ph),
    .done      (done)
);

// File: tb/tb_adc_seq_timer.sv
module tb_adc_seq_timer;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0][4:0] ps_set;
    logic [1:0]      start;
    logic [1:0][1:0] ts_code;
    logic [1:0]      diff;
    logic [1:0]      adc_en, adc_clk, ratio_bad, ratio_err;
    logic [1:0]      busy, sample_ph, conv_ph, done;

    always #10 clk = ~clk;   // 50 MHz

    adc_seq_timer dut (
        .clk(clk), .rst_n(rst_n), .ps_set(ps_set), .start(start),
        .ts_code(ts_code), .diff(diff), .adc_en(adc_en), .adc_clk(adc_clk),
        .ratio_bad(ratio_bad), .ratio_err(ratio_err), .busy(busy),
        .sample_ph(sample_ph), .conv_ph(conv_ph), .done(done)
    );

    typedef struct { int slen; int clen; } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    longint last_t [2];
    bit     have_last [2];
    bit     per_reset [2];
    int     exp_per [2];
    string  per_req [2];
    int     hi_run [2];
    bit     last_en [2];
    int     scnt [2];
    int     ccnt [2];
    bit     done_prev [2];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int slen_of(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 8 : (c == 2'd2) ? 64 : 128;
    endfunction

    // Driver: issue a start and record what the scoreboard should see.
    task automatic launch(input int i, input logic [1:0] c, input logic d);
        exp_t e;
        @(posedge clk); #1;
        ts_code[i] = c; diff[i] = d; start[i] = 1'b1;
        e.slen = slen_of(c);
        e.clen = d ? 13 : 14;
        if (i == 0) q0.push_back(e); else q1.push_back(e);
        @(posedge clk); #1;
        start[i] = 1'b0;
    endtask

    // A start pulse that the design must ignore; nothing is recorded.
    task automatic poke(input int i);
        @(posedge clk); #1; start[i] = 1'b1;
        @(posedge clk); #1; start[i] = 1'b0;
    endtask

    task automatic wait_idle(input int i);
        do @(negedge clk); while (busy[i]);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Change the code while idle, then re-arm the period monitor.
    task automatic set_ratio(input int i, input logic [4:0] n);
        @(posedge clk); #1; ps_set[i] = n;
        cycles(2);
        exp_per[i]   = 2 * (int'(n) + 1);
        per_req[i]   = "R1";
        per_reset[i] = 1'b1;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                exp_t e;
                bit   got;
                if (per_reset[i]) begin have_last[i] = 1'b0; per_reset[i] = 1'b0; end
                if (adc_en[i]) begin
                    if (have_last[i])
                        chk((cyc - last_t[i]) == exp_per[i], per_req[i], "adc_en spacing",
                            cyc - last_t[i], exp_per[i]);
                    have_last[i] = 1'b1;
                    last_t[i]    = cyc;
                end
                if (adc_clk[i]) begin
                    hi_run[i]++;
                    last_en[i] = adc_en[i];
                end else begin
                    if (hi_run[i] > 0 && last_en[i])
                        chk(hi_run[i] == exp_per[i] / 2, "R4", "adc_clk high run",
                            hi_run[i], exp_per[i] / 2);
                    hi_run[i]  = 0;
                    last_en[i] = 1'b0;
                end
                if (done_prev[i])
                    chk(!busy[i], "R8", "busy after done", busy[i], 0);
                if (sample_ph[i] && adc_en[i]) scnt[i]++;
                if (conv_ph[i] && adc_en[i])   ccnt[i]++;
                if (done[i]) begin
                    got = (i == 0) ? (q0.size() > 0) : (q1.size() > 0);
                    chk(got, "R9", "done with no accepted start", 1, 0);
                    if (got) begin
                        e = (i == 0) ? q0.pop_front() : q1.pop_front();
                        chk(scnt[i] == e.slen, "R6", "sample enables", scnt[i], e.slen);
                        chk(ccnt[i] == e.clen, "R7", "convert enables", ccnt[i], e.clen);
                    end
                    chk(adc_en[i], "R8", "done aligned to adc_en", adc_en[i], 1);
                    scnt[i] = 0;
                    ccnt[i] = 0;
                end
                done_prev[i] = done[i];
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int en_seen;
        for (int i = 0; i < 2; i++) begin
            have_last[i] = 0; per_reset[i] = 0; hi_run[i] = 0; last_en[i] = 0;
            scnt[i] = 0; ccnt[i] = 0; done_prev[i] = 0; per_req[i] = "R1";
        end
        exp_per[0] = 10; exp_per[1] = 20;
        ps_set[0] = 5'd4; ps_set[1] = 5'd9;
        start = '0; ts_code = '0; diff = '0;

        // R11: reset state
        repeat (4) @(negedge clk);
        chk({adc_en, adc_clk, busy, sample_ph, conv_ph, done, ratio_err, ratio_bad} == '0,
            "R11", "outputs during reset",
            {adc_en, adc_clk, busy, sample_ph, conv_ph, done, ratio_err, ratio_bad}, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R1, R4, R10: free-running enables at two ratios
        cycles(120);
        chk(ratio_bad == 2'b00, "R2", "code 4 and 9 legal", ratio_bad, 0);

        // R6, R7: shortest conversion, differential
        launch(0, 2'd0, 1'b1);
        wait_idle(0);

        // R10: both instances converting at once
        launch(0, 2'd1, 1'b0);
        launch(1, 2'd2, 1'b1);
        wait_idle(0);
        wait_idle(1);

        // R9: start while busy is ignored
        launch(1, 2'd3, 1'b0);
        cycles(50);
        poke(1);
        wait_idle(1);
        cycles(5);
        chk(!busy[1], "R9", "no conversion from start while busy", busy[1], 0);

        // R5: code change during a conversion is deferred
        launch(0, 2'd1, 1'b1);
        cycles(20);
        ps_set[0]  = 5'd6;
        per_req[0] = "R5";
        wait_idle(0);
        @(posedge clk);
        @(posedge clk); #1;
        exp_per[0]   = 14;
        per_req[0]   = "R1";
        per_reset[0] = 1'b1;
        cycles(80);
        launch(0, 2'd0, 1'b0);
        wait_idle(0);

        // R2, R3, R9: illegal code at the boundary
        set_ratio(0, 5'd3);
        @(negedge clk);
        chk(ratio_bad[0], "R2", "code 3 flagged", ratio_bad[0], 1);
        chk(ratio_err[0], "R3", "error latched", ratio_err[0], 1);
        chk(!ratio_err[1], "R10", "other instance error clear", ratio_err[1], 0);
        poke(0);
        cycles(3);
        chk(!busy[0], "R9", "start refused on illegal code", busy[0], 0);
        en_seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (adc_en[0] || adc_clk[0]) en_seen++;
        end
        chk(en_seen == 0, "R2", "no clock on illegal code", en_seen, 0);

        // R3: error persists after a legal code
        set_ratio(0, 5'd4);
        @(negedge clk);
        chk(!ratio_bad[0], "R2", "code 4 legal", ratio_bad[0], 0);
        chk(ratio_err[0], "R3", "error sticky", ratio_err[0], 1);
        cycles(60);
        launch(0, 2'd2, 1'b0);
        wait_idle(0);
        cycles(5);
        chk(q0.size() == 0 && q1.size() == 0, "R6", "all conversions completed",
            q0.size() + q1.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule